// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the slave side of a four-wire serial link that a host uses to program a bank of 8-bit configuration registers. The host pulls the enable line low, toggles the serial clock and shifts 16-bit words in, most significant bit first. Each word carries an address byte followed by a data byte. One enable window may hold several words back to back. Any bits left over after the last complete word are dropped when the enable line goes high again.

The serial inputs are resynchronised into the system clock domain, and their edges are detected there. No logic is clocked by the serial clock itself. A read word returns the selected register on the serial output while its data byte is being shifted. After a read word, the port stays in a read state across windows, and in that state it blocks writes. A write to a dedicated reset bit returns the whole bank to its defaults. The register contents leave the block as one flat vector.

Top module: `cfg_serial_regs`

## Requirements
- R1: Bits on `sdata_i` are taken only on rising edges of `sclk_i` while `sen_i` is low. Serial clock edges while `sen_i` is high change neither the registers nor the outputs.
- R2: A word is 16 bits, sent MSB first. The address byte comes first: bit 7 is the direction flag (0 = write, 1 = read), bit 6 must be 0, and bits 5..0 select the register. The data byte follows. A write word updates its register after the 16th rising edge.
- R3: Several words may follow one another in one enable window. A trailing partial word has no effect, even when its address byte is complete. This includes not changing the read state.
- R4: In a read word, bit 7 of the selected register appears on `sdout_o` after the 8th rising edge. Each later rising edge up to the 15th moves to the next lower bit, so the host can capture the byte on falling edges.
- R5: A complete read word puts the port into a read state that survives enable windows. In that state, the next word with direction 0 only leaves the read state and its data is dropped. Later write words take effect.
- R6: `sdout_oe_o` is high only from the 8th to the 16th rising edge of a read word. It is low whenever `sen_i` is high. While it is low, `sdout_o` is 0 and the pad is meant to float.
- R7: Writing register 8 with data bit 0 set loads every register with its default. Register 8 then reads bit 0 as 0.
- R8: After reset, register 6 holds 80h, register 13 holds 6Ch, register 31 holds 7Fh, and every other register holds 00h. Register i is exported on `regs_o[8i+7:8i]`.
- R9: An address with bit 6 set, or a register number of `NUM_REGS` or more, reads back 00h. A write to such an address changes no register.
- R10: Each serial clock phase lasts at least 4 system clock cycles. `sdout_o` settles within 4 system clock cycles after a rising serial clock edge (with 2 synchroniser stages).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sen_i | input | 1 | Serial enable, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdata_i | input | 1 | Serial data in |
| sdout_o | output | 1 | Serial read data |
| sdout_oe_o | output | 1 | Output enable for the serial data pad |
| regs_o | output | NUM_REGS*8 | Register contents, register i in byte i |

## Verification
The hardest case to reach from the pins is how the sticky read state interacts with words that are cut short. One case is a partial word whose address byte names a read. The other is an unlock word that arrives in a later window than the read that locked the port. The random stimulus mixes 1 to 3 whole words per window with an optional trailing fragment of 1 to 15 bits. It draws the direction flag, bit 6 and out-of-range register numbers on purpose, so the lock, the unlock and the fragments meet in many orders. Directed windows pin down each of these transitions one at a time.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam int SEL_W  = BYTE_W - 1;

    typedef logic [BYTE_W-1:0] byte_t;

    // Power-on contents of each register; anything not listed starts at zero.
    function automatic byte_t reg_default(input int unsigned idx);
        case (idx)
            6:       return 8'h80;
            13:      return 8'h6C;
            31:      return 8'h7F;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfgs_sync.sv
module cfgs_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/cfgs_frame.sv
module cfgs_frame
    import cfgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sen_s,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic              bit_ev_o,
    output logic              addr_ev_o,
    output logic              word_ev_o,
    output logic [WORD_W-1:0] sh_o
);
    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              bit_ev;
        logic              addr_ev;
        logic              word_ev;
    } st_t;

    st_t  st_d, st_q;
    logic rise;

    always_comb begin
        st_d           = st_q;
        rise           = sclk_s & ~st_q.sclk_prev;
        st_d.sclk_prev = sclk_s;
        st_d.bit_ev    = 1'b0;
        st_d.addr_ev   = 1'b0;
        st_d.word_ev   = 1'b0;
        if (sen_s) begin
            // enable released: any fragment is forgotten
            st_d.cnt = '0;
        end else if (rise) begin
            st_d.sh      = {st_q.sh[WORD_W-2:0], sdata_s};
            st_d.cnt     = st_q.cnt + 1'b1;
            st_d.bit_ev  = 1'b1;
            st_d.addr_ev = (st_q.cnt == CNT_W'(BYTE_W - 1));
            st_d.word_ev = (st_q.cnt == CNT_W'(WORD_W - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bit_ev_o  = st_q.bit_ev;
    assign addr_ev_o = st_q.addr_ev;
    assign word_ev_o = st_q.word_ev;
    assign sh_o      = st_q.sh;

    assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> (st_q.cnt == '0));
    assert_event_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_q.addr_ev, st_q.word_ev}));
    assert_word_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.word_ev |-> (st_q.cnt == '0));
endmodule

// File: rtl/cfgs_rdport.sv
module cfgs_rdport
    import cfgs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  sen_s,
    input  logic  bit_ev_i,
    input  logic  addr_ev_i,
    input  logic  word_ev_i,
    input  logic  addr_rw_i,
    input  logic  word_rw_i,
    input  byte_t rd_data_i,
    output logic  wr_en_o,
    output logic  sdout_o,
    output logic  sdout_oe_o
);
    typedef struct packed {
        logic  rd_mode;
        logic  oe;
        byte_t out_sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        // a whole write word lands only when the port is unlocked
        wr_en_o = word_ev_i & ~st_q.rd_mode & ~word_rw_i;
        if (word_ev_i) begin
            st_d.rd_mode = word_rw_i;
            st_d.oe      = 1'b0;
        end else if (addr_ev_i) begin
            st_d.oe     = addr_rw_i;
            st_d.out_sh = rd_data_i;
        end else if (bit_ev_i && st_q.oe) begin
            st_d.out_sh = {st_q.out_sh[BYTE_W-2:0], 1'b0};
        end
        if (sen_s) st_d.oe = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdout_o    = st_q.oe & st_q.out_sh[BYTE_W-1];
    assign sdout_oe_o = st_q.oe;

    assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> !st_q.oe);
    assert_quiet_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sdout_oe_o |-> !sdout_o);
    assert_read_locks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_ev_i && word_rw_i) |=> st_q.rd_mode);
    assert_lock_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rd_mode && !word_ev_i) |=> st_q.rd_mode);
endmodule

// File: rtl/cfgs_bank.sv
module cfgs_bank
    import cfgs_pkg::*;
#(
    parameter int NUM_REGS  = 33,
    parameter int SWRST_IDX = 8,
    parameter int SWRST_BIT = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [SEL_W-1:0]           wr_sel_i,
    input  byte_t                      wr_data_i,
    input  logic [SEL_W-1:0]           rd_sel_i,
    output byte_t                      rd_data_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    localparam int IDX_W = $clog2(NUM_REGS);

    typedef logic [NUM_REGS-1:0][BYTE_W-1:0] bank_t;

    function automatic bank_t build_defaults();
        bank_t b;
        for (int i = 0; i < NUM_REGS; i++) b[i] = reg_default(i);
        return b;
    endfunction

    localparam bank_t DEFAULTS = build_defaults();

    function automatic logic is_hit(input logic [SEL_W-1:0] sel);
        return int'(sel) < NUM_REGS;
    endfunction

    bank_t            bank_d, bank_q;
    logic             wr_hit, swrst_hit;
    logic [IDX_W-1:0] wr_idx, rd_idx;

    always_comb begin
        bank_d    = bank_q;
        wr_idx    = wr_sel_i[IDX_W-1:0];
        rd_idx    = rd_sel_i[IDX_W-1:0];
        wr_hit    = wr_en_i & is_hit(wr_sel_i);
        swrst_hit = wr_hit & (int'(wr_sel_i) == SWRST_IDX) & wr_data_i[SWRST_BIT];
        if (swrst_hit)   bank_d = DEFAULTS;
        else if (wr_hit) bank_d[wr_idx] = wr_data_i;
        rd_data_o = is_hit(rd_sel_i) ? bank_q[rd_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= DEFAULTS;
        else        bank_q <= bank_d;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_export
        assign regs_o[g*BYTE_W +: BYTE_W] = bank_q[g];
    end

    assert_swrst_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && int'(wr_sel_i) == SWRST_IDX && wr_data_i[SWRST_BIT])
        |=> (bank_q[SWRST_IDX][SWRST_BIT] == 1'b0));
    assert_miss_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !is_hit(wr_sel_i)) |=> $stable(bank_q));
    assert_idle_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(bank_q));
endmodule

// File: rtl/cfg_serial_regs.sv
module cfg_serial_regs
    import cfgs_pkg::*;
#(
    parameter int NUM_REGS    = 33,
    parameter int SYNC_STAGES = 2,
    parameter int SWRST_IDX   = 8,
    parameter int SWRST_BIT   = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sen_i,
    input  logic                       sclk_i,
    input  logic                       sdata_i,
    output logic                       sdout_o,
    output logic                       sdout_oe_o,
    output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
    logic [2:0]        raw_in, sync_in;
    logic              bit_ev, addr_ev, word_ev, wr_en;
    logic [WORD_W-1:0] sh;
    byte_t             rd_data;

    assign raw_in = {sen_i, sclk_i, sdata_i};

    cfgs_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    cfgs_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sen_s     (sync_in[2]),
        .sclk_s    (sync_in[1]),
        .sdata_s   (sync_in[0]),
        .bit_ev_o  (bit_ev),
        .addr_ev_o (addr_ev),
        .word_ev_o (word_ev),
        .sh_o      (sh)
    );

    cfgs_rdport u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .sen_s      (sync_in[2]),
        .bit_ev_i   (bit_ev),
        .addr_ev_i  (addr_ev),
        .word_ev_i  (word_ev),
        .addr_rw_i  (sh[BYTE_W-1]),
        .word_rw_i  (sh[WORD_W-1]),
        .rd_data_i  (rd_data),
        .wr_en_o    (wr_en),
        .sdout_o    (sdout_o),
        .sdout_oe_o (sdout_oe_o)
    );

    cfgs_bank #(.NUM_REGS(NUM_REGS), .SWRST_IDX(SWRST_IDX), .SWRST_BIT(SWRST_BIT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_sel_i  (sh[WORD_W-2:BYTE_W]),
        .wr_data_i (sh[BYTE_W-1:0]),
        .rd_sel_i  (sh[BYTE_W-2:0]),
        .rd_data_o (rd_data),
        .regs_o    (regs_o)
    );
endmodule

// File: tb/cfg_serial_regs_test.sv
module cfg_serial_regs_test;
    localparam int NUM_REGS = 33;

    logic clk = 1'b0, rst_n = 1'b0, sen = 1'b1, sclk = 1'b0, sdata = 1'b0;
    wire  sdout, sdout_oe;
    wire  [NUM_REGS*8-1:0] regs;

    always #2 clk = ~clk;

    cfg_serial_regs #(.NUM_REGS(NUM_REGS)) uut (
        .clk(clk), .rst_n(rst_n), .sen_i(sen), .sclk_i(sclk), .sdata_i(sdata),
        .sdout_o(sdout), .sdout_oe_o(sdout_oe), .regs_o(regs)
    );

    int errors = 0, checks = 0, half = 8;
    bit done = 1'b0, m_rd = 1'b0;
    logic [7:0] model [NUM_REGS];

    function automatic logic [7:0] exp_default(input int i);
        if (i == 6)  return 8'h80;
        if (i == 13) return 8'h6C;
        if (i == 31) return 8'h7F;
        return 8'h00;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_defaults();
        for (int i = 0; i < NUM_REGS; i++) model[i] = exp_default(i);
    endtask

    task automatic chk_regs(input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ok && regs[i*8 +: 8] !== model[i]) begin ok = 1'b0; bad = i; end
        end
        chk(ok, req, {bad[7:0], regs[bad*8 +: 8]}, {bad[7:0], model[bad]});
    endtask

    task automatic open_win();
        sen = 1'b0; tick(half);
    endtask

    task automatic close_win();
        tick(half); sen = 1'b1; tick(half + 8);
        chk(sdout_oe === 1'b0, "R6 oe low after window", 32'(sdout_oe), 0);
    endtask

    // Send one full word, predict it with the model and check the read data and enable.
    task automatic send_word(input logic [7:0] a, input logic [7:0] d);
        logic [15:0] w = {a, d};
        logic [7:0]  got = '0, exp_rd;
        bit          oe_ok = 1'b1, valid;
        for (int k = 0; k < 16; k++) begin
            sdata = w[15-k]; tick(half); sclk = 1'b1; tick(half);
            if (k >= 7 && k <= 14) begin
                got = {got[6:0], sdout};
                if (sdout_oe !== a[7]) oe_ok = 1'b0;
            end else if (sdout_oe !== 1'b0) oe_ok = 1'b0;
            sclk = 1'b0;
        end
        valid  = (a[6] == 1'b0) && (int'(a[5:0]) < NUM_REGS);
        exp_rd = (a[7] && valid) ? model[a[5:0]] : 8'h00;
        if (a[7]) chk(got === exp_rd, valid ? "R4 read data" : "R9 miss reads zero", {a, got}, {a, exp_rd});
        chk(oe_ok, "R6 enable window", 32'(oe_ok), 1);
        if (!m_rd && !a[7] && valid) begin
            if (a[5:0] == 6'd8 && d[0]) model_defaults();
            else model[a[5:0]] = d;
        end
        m_rd = a[7];
    endtask

    task automatic send_bits(input int n, input logic [15:0] w);
        for (int k = 0; k < n; k++) begin
            sdata = w[15-k]; tick(half); sclk = 1'b1; tick(half); sclk = 1'b0;
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog act=0 exp=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_defaults();
        tick(5); rst_n = 1'b1; tick(5);

        // R8 reset contents and layout
        chk_regs("R8 reset bank");
        chk(regs[6*8 +: 8] === 8'h80, "R8 reg6", 32'(regs[6*8 +: 8]), 32'h80);
        chk(regs[13*8 +: 8] === 8'h6C, "R8 reg13", 32'(regs[13*8 +: 8]), 32'h6C);
        chk(regs[31*8 +: 8] === 8'h7F, "R8 reg31", 32'(regs[31*8 +: 8]), 32'h7F);
        chk(sdout_oe === 1'b0 && sdout === 1'b0, "R6 reset pin", {sdout_oe, sdout}, 0);

        // R2 write then R4 read back, unlock with a write word (R5)
        open_win(); send_word(8'h0B, 8'h5A); close_win();
        chk(regs[11*8 +: 8] === 8'h5A, "R2 write lands", 32'(regs[11*8 +: 8]), 32'h5A);
        open_win(); send_word(8'h8B, 8'h00); send_word(8'h00, 8'h00); close_win();

        // R3 two words in a window plus a trailing fragment
        open_win(); send_word(8'h10, 8'hC3); send_word(8'h11, 8'h3C);
        send_bits(11, 16'h12FF); close_win();
        chk_regs("R3 multi word and fragment");
        chk(regs[18*8 +: 8] === 8'h00, "R3 fragment dropped", 32'(regs[18*8 +: 8]), 0);

        // R1 serial clock with enable high does nothing
        for (int k = 0; k < 24; k++) begin
            sdata = 1'($urandom); tick(4); sclk = 1'b1; tick(4); sclk = 1'b0;
        end
        tick(8);
        chk_regs("R1 ignored while disabled");
        chk(sdout_oe === 1'b0, "R1 no enable while disabled", 32'(sdout_oe), 0);

        // R5 sticky read state across windows
        open_win(); send_word(8'h86, 8'h00); close_win();
        open_win(); send_word(8'h0B, 8'h11); close_win();
        chk(regs[11*8 +: 8] === 8'h5A, "R5 unlock word dropped", 32'(regs[11*8 +: 8]), 32'h5A);
        open_win(); send_word(8'h0B, 8'h22); close_win();
        chk(regs[11*8 +: 8] === 8'h22, "R5 write after unlock", 32'(regs[11*8 +: 8]), 32'h22);

        // R3 fragment with a complete read address must not lock
        open_win(); send_bits(10, 16'h8BFF); close_win();
        open_win(); send_word(8'h0B, 8'h44); close_win();
        chk(regs[11*8 +: 8] === 8'h44, "R3 partial read no lock", 32'(regs[11*8 +: 8]), 32'h44);

        // R7 software reset
        open_win(); send_word(8'h10, 8'h33); send_word(8'h08, 8'h15); close_win();
        chk_regs("R7 defaults reloaded");
        chk(regs[8*8] === 1'b0, "R7 self clear", 32'(regs[8*8]), 0);

        // R9 unimplemented and bit-6 addresses
        open_win(); send_word(8'h25, 8'hAA); send_word(8'h4B, 8'h99);
        send_word(8'hA5, 8'h00); send_word(8'hCB, 8'h00); send_word(8'h00, 8'h00); close_win();
        chk_regs("R9 misses discarded");

        // R10 minimum phase length
        half = 4;
        open_win(); send_word(8'h0C, 8'hB7); send_word(8'h8C, 8'h00); send_word(8'h00, 8'h00); close_win();
        chk(regs[12*8 +: 8] === 8'hB7, "R10 fast clock write", 32'(regs[12*8 +: 8]), 32'hB7);
        half = 8;

        // Random windows
        for (int t = 0; t < 40; t++) begin
            int nw = int'($urandom_range(1, 3));
            open_win();
            for (int j = 0; j < nw; j++) begin
                logic [7:0] a;
                a[7]   = ($urandom_range(0, 2) == 0);
                a[6]   = ($urandom_range(0, 7) == 0);
                a[5:0] = 6'($urandom_range(0, 40));
                send_word(a, 8'($urandom));
            end
            if ($urandom_range(0, 1) == 1) send_bits(int'($urandom_range(1, 15)), 16'($urandom));
            close_win();
            chk_regs("R2 random bank compare");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule